// File: doc/BRIEF.md
# Conditional Reset Row Sequencer for a Multi-Check Wide-Dynamic-Range Imager

This block is the digital control for an imager that runs several saturation checks in each frame to extend its dynamic range. Each check is started with a command. The block then walks the pixel rows one at a time, from the first row to the last. For each row it reads one flag bit per pixel from an on-chip flag store and combines that bit with the column comparator results for the row. The comparator bit is high when the pixel level is below the range threshold. From these two bits it decides which pixels to reset.

The decision for a row is written back to the flag store as a whole row. The same decision drives the per-pixel reset lines and leaves the block as one word on a valid/ready stream, where the bits are added into an off-chip count. A one-hot shift register selects the row in place of an address decoder.

At the end of a frame an initial-reset command does two things in one cycle: it raises every reset line in every row, and it sets every flag bit. The first check of a frame carries a flag that ignores the stored bits.

The output stream obeys these back-pressure rules:
- While `out_ready` is low, a presented word stays valid and unchanged.
- The row pointer advances only on a completed handshake.
- A new check cannot start until the last row of the previous check has been accepted.

Top module: `wdr_row_seq`

## Requirements
- R1: After reset, `busy`, `out_valid`, `ld_out` and `row_sel` are all zero and every flag bit is 0. A later check that is not the first of a frame therefore emits all-zero rows, whatever the comparators report.
- R2: On a check started with `first_check` high, each emitted row equals `cmp_in` as sampled for that row. Bit i of a word is column i.
- R3: On a check started with `first_check` low, each emitted row equals `cmp_in` ANDed with that row's flags from the previous check. The emitted row is also stored as the row's new flags.
- R4: While `out_valid` is high, `ld_out` equals `out_data` and `row_sel` is one-hot, with bit r selecting row r.
- R5: Rows are emitted in order from row 0 to row ROWS-1, exactly once per check. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R6: `busy` rises in the cycle after an accepted `start_check` and falls in the cycle after the last row's handshake. A `start_check` seen while `busy` is high has no effect. While `busy` is low, `out_valid`, `ld_out` and `row_sel` are zero.
- R7: An `init_reset` seen while `busy` is low drives `ld_out` and `row_sel` to all ones for exactly one cycle, with `busy` high in that cycle. It also sets every flag bit to 1, so the next check that is not the first of a frame emits `cmp_in` unchanged.
- R8: An `init_reset` seen while `busy` is high has no effect on the outputs or on the flags.
- R9: If `start_check` and `init_reset` are both high in the same idle cycle, the initial reset is taken and the start is dropped. No row is emitted afterwards.
- R10: Each row takes three cycles: read, decide and write back, then output. The first row's word is valid in the third cycle after the accepted start. With `out_ready` held high, each following word is valid three cycles after the previous handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_check | input | 1 | Starts one saturation check when idle |
| first_check | input | 1 | Sampled with start_check; ignores the stored flags |
| init_reset | input | 1 | End-of-frame reset of all pixels and flags when idle |
| cmp_in | input | COLS | Column comparator results for the selected row |
| ld_out | output | COLS | Per-pixel reset lines for the selected row(s) |
| row_sel | output | ROWS | One-hot row select; all ones during the initial reset |
| busy | output | 1 | High from an accepted command until its last row is accepted |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | COLS | New flag row sent for off-chip accumulation |

## Verification
Two things can fall in the same cycle: a start command and an end-of-frame initial reset. The bench raises both in one idle cycle. It checks that the reset lines and row select go to all ones for a single cycle, that `busy` then drops, and that no row word appears afterwards. The flags are then read back through a check that is not the first of a frame: its output must equal the comparator pattern, which shows that the bulk set took effect. A second overlap is an initial reset or a repeated start arriving during a check. Both are judged by the emitted row sequence and by the flag contents seen in the next check.

// File: rtl/wdr_pkg.sv
package wdr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_DECIDE = 3'd2,
    ST_SEND   = 3'd3,
    ST_INIT   = 3'd4
  } seq_state_t;
endpackage

// File: rtl/wdr_row_ptr.sv
// One-hot row pointer built as a shift register.
module wdr_row_ptr #(
  parameter int ROWS = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            shift,
  input  logic            clear,
  output logic [ROWS-1:0] ptr,
  output logic            last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr <= '0;
    else if (clear) ptr <= '0;
    else if (load)  ptr <= {{(ROWS-1){1'b0}}, 1'b1};
    else if (shift) ptr <= {ptr[ROWS-2:0], 1'b0};
  end

  assign last = ptr[ROWS-1];
endmodule

// File: rtl/wdr_flag_store.sv
// One flag bit per pixel, whole-row access through a one-hot select.
module wdr_flag_store #(
  parameter int ROWS = 128,
  parameter int COLS = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ROWS-1:0] sel,
  input  logic            wr_en,
  input  logic [COLS-1:0] wr_data,
  input  logic            set_all,
  output logic [COLS-1:0] rd_data
);
  logic [COLS-1:0] mem [ROWS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mem[r] <= '0;
    end else if (set_all) begin
      for (int r = 0; r < ROWS; r++) mem[r] <= '1;
    end else if (wr_en) begin
      for (int r = 0; r < ROWS; r++)
        if (sel[r]) mem[r] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int r = 0; r < ROWS; r++)
      if (sel[r]) rd_data = rd_data | mem[r];
  end
endmodule

// File: rtl/wdr_decide.sv
// Per-pixel conditional reset decision.
module wdr_decide #(
  parameter int COLS = 256
) (
  input  logic [COLS-1:0] cmp,
  input  logic [COLS-1:0] prev,
  input  logic            first,
  output logic [COLS-1:0] decision
);
  assign decision = cmp & (first ? {COLS{1'b1}} : prev);
endmodule

// File: rtl/wdr_row_seq.sv
module wdr_row_seq
  import wdr_pkg::*;
#(
  parameter int ROWS = 128,
  parameter int COLS = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_check,
  input  logic            first_check,
  input  logic            init_reset,
  input  logic [COLS-1:0] cmp_in,
  output logic [COLS-1:0] ld_out,
  output logic [ROWS-1:0] row_sel,
  output logic            busy,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [COLS-1:0] out_data
);
  seq_state_t      state;
  logic            first_q;
  logic [COLS-1:0] rd_q;
  logic [COLS-1:0] dec_q;
  logic [COLS-1:0] mem_rd;
  logic [COLS-1:0] dec_now;
  logic [ROWS-1:0] ptr;
  logic            ptr_last;

  logic idle, take_init, take_start, handshake;

  assign idle       = (state == ST_IDLE);
  assign take_init  = idle && init_reset;
  assign take_start = idle && start_check && !init_reset;
  assign handshake  = (state == ST_SEND) && out_ready;

  wdr_row_ptr #(.ROWS(ROWS)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (take_start),
    .shift (handshake && !ptr_last),
    .clear (handshake && ptr_last),
    .ptr   (ptr),
    .last  (ptr_last)
  );

  wdr_flag_store #(.ROWS(ROWS), .COLS(COLS)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (ptr),
    .wr_en   (state == ST_DECIDE),
    .wr_data (dec_now),
    .set_all (take_init),
    .rd_data (mem_rd)
  );

  wdr_decide #(.COLS(COLS)) u_dec (
    .cmp      (cmp_in),
    .prev     (rd_q),
    .first    (first_q),
    .decision (dec_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      first_q <= 1'b0;
      rd_q    <= '0;
      dec_q   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (take_init) state <= ST_INIT;
          else if (take_start) begin
            state   <= ST_READ;
            first_q <= first_check;
          end
        end
        ST_READ: begin
          rd_q  <= mem_rd;
          state <= ST_DECIDE;
        end
        ST_DECIDE: begin
          dec_q <= dec_now;
          state <= ST_SEND;
        end
        ST_SEND: begin
          if (out_ready) state <= ptr_last ? ST_IDLE : ST_READ;
        end
        ST_INIT: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = !idle;
  assign out_valid = (state == ST_SEND);
  assign out_data  = out_valid ? dec_q : '0;
  assign ld_out    = (state == ST_INIT) ? {COLS{1'b1}} : out_data;
  assign row_sel   = (state == ST_INIT) ? {ROWS{1'b1}} : (idle ? '0 : ptr);
endmodule

// File: rtl/wdr_row_seq_chk.sv
module wdr_row_seq_chk #(
  parameter int ROWS = 128,
  parameter int COLS = 256
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_check,
  input logic            init_reset,
  input logic [COLS-1:0] ld_out,
  input logic [ROWS-1:0] row_sel,
  input logic            busy,
  input logic            out_valid,
  input logic            out_ready,
  input logic [COLS-1:0] out_data
);
  AST_SEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R5

  AST_LD_MATCHES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (ld_out == out_data && $countones(row_sel) == 1)); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!out_valid && ld_out == '0 && row_sel == '0)); // R6

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start_check && !init_reset && !busy) |=> (busy && !out_valid)); // R6

  AST_INIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (init_reset && !busy) |=> ((&ld_out) && (&row_sel) && busy)); // R7

  AST_INIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((&row_sel) && !out_valid) |=> !busy); // R9
endmodule

bind wdr_row_seq wdr_row_seq_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_check (start_check),
  .init_reset  (init_reset),
  .ld_out      (ld_out),
  .row_sel     (row_sel),
  .busy        (busy),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data)
);

// File: tb/tb_wdr_row_seq.sv
module tb_wdr_row_seq;
  localparam int ROWS = 8;
  localparam int COLS = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start_check = 1'b0;
  logic            first_check = 1'b0;
  logic            init_reset = 1'b0;
  logic [COLS-1:0] cmp_in = '0;
  logic [COLS-1:0] ld_out;
  logic [ROWS-1:0] row_sel;
  logic            busy;
  logic            out_valid;
  logic            out_ready = 1'b0;
  logic [COLS-1:0] out_data;

  int checks = 0;
  int fails  = 0;
  logic [COLS-1:0] flags [ROWS];

  always #2 clk = ~clk;

  wdr_row_seq #(.ROWS(ROWS), .COLS(COLS)) dut (
    .clk(clk), .rst_n(rst_n), .start_check(start_check), .first_check(first_check),
    .init_reset(init_reset), .cmp_in(cmp_in), .ld_out(ld_out), .row_sel(row_sel),
    .busy(busy), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Run a full check; new flags are modelled here from the requirements.
  task automatic run_check(input logic first, input logic [COLS-1:0] cmp,
                           input int stall, input logic poke);
    cmp_in = cmp;
    @(negedge clk);
    first_check = first; start_check = 1'b1;
    @(negedge clk);
    start_check = 1'b0;
    chk("R6 busy after start", busy, 1);
    for (int r = 0; r < ROWS; r++) begin
      int waited = 1;
      logic [COLS-1:0] exp;
      exp = cmp & (first ? {COLS{1'b1}} : flags[r]);
      if (poke) begin start_check = 1'b1; init_reset = 1'b1; end
      while (!out_valid && waited < 20) begin
        @(negedge clk); waited++;
        start_check = 1'b0; init_reset = 1'b0;
      end
      chk("R10 three-cycle row", waited, 3);
      chk(first ? "R2 row word" : "R3 row word", out_data, exp);
      chk("R5 row order", row_sel, 64'(1) << r);
      chk("R4 ld equals word", ld_out, out_data);
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk("R5 hold valid", out_valid, 1);
        chk("R5 hold data", out_data, exp);
      end
      flags[r] = exp;
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end
    chk("R6 busy falls after last row", busy, 0);
    chk("R6 idle no valid", out_valid, 0);
  endtask

  task automatic test_reset();
    chk("R1 busy", busy, 0);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 ld_out", ld_out, 0);
    chk("R1 row_sel", row_sel, 0);
    run_check(1'b0, '1, 0, 1'b0); // R1: cleared flags give zero rows
  endtask

  task automatic test_first();
    run_check(1'b1, 16'hA5A5, 0, 1'b0); // R2
  endtask

  task automatic test_conditional();
    run_check(1'b0, 16'h0FF0, 2, 1'b0); // R3 with back-pressure R5
    run_check(1'b0, 16'hFFFF, 1, 1'b0); // R3 keeps ANDing
  endtask

  task automatic test_init();
    @(negedge clk);
    init_reset = 1'b1;
    @(negedge clk);
    init_reset = 1'b0;
    chk("R7 ld all ones", ld_out, {COLS{1'b1}});
    chk("R7 row_sel all ones", row_sel, {ROWS{1'b1}});
    chk("R7 busy during init", busy, 1);
    @(negedge clk);
    chk("R7 init one cycle", ld_out, 0);
    chk("R7 busy after init", busy, 0);
    for (int r = 0; r < ROWS; r++) flags[r] = '1;
    run_check(1'b0, 16'h3C3C, 0, 1'b0); // R7: flags all set
  endtask

  task automatic test_ignored_while_busy();
    // R8 and R6: init and start poked during a check are ignored
    run_check(1'b1, 16'h0000, 0, 1'b1);
    repeat (4) begin
      @(negedge clk);
      chk("R6 no restart", busy, 0);
    end
    run_check(1'b0, '1, 0, 1'b0); // R8: flags still zero
  endtask

  task automatic test_collision();
    @(negedge clk);
    start_check = 1'b1; init_reset = 1'b1; first_check = 1'b1;
    @(negedge clk);
    start_check = 1'b0; init_reset = 1'b0;
    chk("R9 init wins ld", ld_out, {COLS{1'b1}});
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R9 start dropped", {busy, out_valid}, 0);
    end
    for (int r = 0; r < ROWS; r++) flags[r] = '1;
    run_check(1'b0, 16'h1234, 0, 1'b0); // R9: flags were set by the init
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int r = 0; r < ROWS; r++) flags[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_first();
    test_conditional();
    test_init();
    test_ignored_while_busy();
    test_collision();
    finish_run();
  end
endmodule